// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Cross Half-Word Dot Product

This block is the arithmetic core of a DSP datapath: a filter tap, a correlator or a transform butterfly. Each valid beat carries two 18-bit operands. The beat selects one of three product forms:

- a full signed 18x18 multiply;
- an unsigned 17x17 multiply;
- a packed dot product. Each operand holds two signed 9-bit half-words. The low half of one operand is multiplied by the high half of the other, both ways round, the two products are summed, and the sum is scaled by 2^9.

The product is then folded into a 44-bit running value. By default it is added to the accumulator, or subtracted from it. A load beat instead combines the product with a side input, `addend_in`. That input can carry a cascade value from a neighbouring unit, a constant, or zero to start a fresh sum. The load happens on the same beat as the product, so a new sum begins without an idle slot.

Operands and controls are registered on entry and the accumulator is registered on exit. A result therefore appears two clock edges after its valid beat is sampled. The running value wraps modulo 2^44 and no overflow indication is produced.

Top module: `dsp_mac18`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `out_valid` is 0 and `result` is 0.
- R2: With `mode_in` = 0, the product is the signed two's-complement product of `a_in[17:0]` and `b_in[17:0]`, sign-extended to 44 bits.
- R3: With `mode_in` = 1, the product is `a_in[16:0]` times `b_in[16:0]` as unsigned numbers, zero-extended to 44 bits. Bit 17 of each operand has no effect.
- R4: With `mode_in` = 2, each operand is split into a signed low half-word [8:0] and a signed high half-word [17:9]. The product is (a_low*b_high + a_high*b_low) shifted left by 9, sign-extended to 44 bits.
- R5: `mode_in` = 3 produces the same product as `mode_in` = 0.
- R6: On a valid beat with `load_in` = 0, the new accumulator value is the old accumulator value plus the product (or minus it, see R8).
- R7: On a valid beat with `load_in` = 1, the old accumulator value is discarded. The new value is `addend_in` plus (or minus) the product. Load beats may follow any beat back to back.
- R8: `sub_in` = 1 subtracts the product from the selected base value; `sub_in` = 0 adds it.
- R9: `out_valid` is high exactly two clock edges after `in_valid` is sampled high. `result` keeps its value whenever `out_valid` is low.
- R10: The accumulator wraps modulo 2^44 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat strobe |
| a_in | input | 18 | First operand |
| b_in | input | 18 | Second operand |
| mode_in | input | 2 | Product form: 0 signed, 1 unsigned 17-bit, 2 dot product, 3 same as 0 |
| sub_in | input | 1 | 1 subtracts the product, 0 adds it |
| load_in | input | 1 | 1 uses `addend_in` as the base instead of the accumulator |
| addend_in | input | 44 | Cascade or constant base used on load beats |
| out_valid | output | 1 | Result updated on this cycle |
| result | output | 44 | Accumulator value |

## Verification
A load and a subtraction can be requested on the same beat. Either can also land on the beat directly after an accumulating beat, with no gap between them. Directed sequences place a load-with-subtract right after running sums, and place a wrapping load next to an accumulate. A long stretch of random beats then mixes all modes, loads, subtractions and idle cycles. An independent integer model checks, on every clock, that the base value was chosen first and the sign applied second, so that neither the old accumulator nor the previous addend leaks into the new value.

// File: rtl/mac18_pkg.sv
package mac18_pkg;

  localparam int unsigned MAC_OP_W   = 18;
  localparam int unsigned MAC_HALF_W = 9;
  localparam int unsigned MAC_ACC_W  = 44;

  typedef enum logic [1:0] {
    MODE_S18 = 2'd0,
    MODE_U17 = 2'd1,
    MODE_DOT = 2'd2,
    MODE_RSV = 2'd3
  } mac_mode_e;

endpackage

// File: rtl/mac18_stage.sv
module mac18_stage
  import mac18_pkg::*;
#(
  parameter int unsigned OP_W  = MAC_OP_W,
  parameter int unsigned ACC_W = MAC_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_d,
  input  logic [OP_W-1:0]  a_d,
  input  logic [OP_W-1:0]  b_d,
  input  logic [1:0]       mode_d,
  input  logic             sub_d,
  input  logic             load_d,
  input  logic [ACC_W-1:0] addend_d,
  output logic             valid_q,
  output logic [OP_W-1:0]  a_q,
  output logic [OP_W-1:0]  b_q,
  output mac_mode_e        mode_q,
  output logic             sub_q,
  output logic             load_q,
  output logic [ACC_W-1:0] addend_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      mode_q   <= MODE_S18;
      sub_q    <= 1'b0;
      load_q   <= 1'b0;
      addend_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) begin
        a_q      <= a_d;
        b_q      <= b_d;
        mode_q   <= mac_mode_e'(mode_d);
        sub_q    <= sub_d;
        load_q   <= load_d;
        addend_q <= addend_d;
      end
    end
  end

endmodule

// File: rtl/mac18_product.sv
module mac18_product
  import mac18_pkg::*;
#(
  parameter int unsigned OP_W   = MAC_OP_W,
  parameter int unsigned HALF_W = MAC_HALF_W,
  parameter int unsigned ACC_W  = MAC_ACC_W
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  mac_mode_e        mode,
  output logic [ACC_W-1:0] prod_ext
);

  localparam int unsigned U_W   = OP_W - 1;
  localparam int unsigned HI_W  = OP_W - HALF_W;
  localparam int unsigned XP_W  = HALF_W + HI_W;
  localparam int unsigned SUM_W = XP_W + 1;
  localparam int unsigned SH_W  = SUM_W + HALF_W;

  logic signed [OP_W-1:0]   sa, sb;
  logic signed [2*OP_W-1:0] full_s;
  logic        [2*U_W-1:0]  full_u;
  logic signed [HALF_W-1:0] a_lo, b_lo;
  logic signed [HI_W-1:0]   a_hi, b_hi;
  logic signed [XP_W-1:0]   cross0, cross1;
  logic signed [SUM_W-1:0]  dot_sum;
  logic signed [SH_W-1:0]   dot_scaled;

  assign sa   = a;
  assign sb   = b;
  assign a_lo = a[HALF_W-1:0];
  assign b_lo = b[HALF_W-1:0];
  assign a_hi = a[OP_W-1:HALF_W];
  assign b_hi = b[OP_W-1:HALF_W];

  always_comb begin
    full_s     = sa * sb;
    full_u     = a[U_W-1:0] * b[U_W-1:0];
    cross0     = a_lo * b_hi;
    cross1     = a_hi * b_lo;
    dot_sum    = SUM_W'(cross0) + SUM_W'(cross1);
    dot_scaled = {dot_sum, {HALF_W{1'b0}}};
    unique case (mode)
      MODE_U17: prod_ext = ACC_W'(full_u);
      MODE_DOT: prod_ext = ACC_W'(dot_scaled);
      default:  prod_ext = ACC_W'(full_s);
    endcase
  end

endmodule

// File: rtl/mac18_accum.sv
module mac18_accum
  import mac18_pkg::*;
#(
  parameter int unsigned ACC_W = MAC_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             load,
  input  logic             sub,
  input  logic [ACC_W-1:0] addend,
  input  logic [ACC_W-1:0] prod,
  output logic [ACC_W-1:0] acc,
  output logic             upd_q
);

  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] next_acc;

  assign base     = load ? addend : acc;
  assign next_acc = sub ? (base - prod) : (base + prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd;
      if (upd) acc <= next_acc;
    end
  end

endmodule

// File: rtl/dsp_mac18.sv
module dsp_mac18
  import mac18_pkg::*;
#(
  parameter int unsigned OP_W   = MAC_OP_W,
  parameter int unsigned HALF_W = MAC_HALF_W,
  parameter int unsigned ACC_W  = MAC_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  a_in,
  input  logic [OP_W-1:0]  b_in,
  input  logic [1:0]       mode_in,
  input  logic             sub_in,
  input  logic             load_in,
  input  logic [ACC_W-1:0] addend_in,
  output logic             out_valid,
  output logic [ACC_W-1:0] result
);

  logic             s1_valid;
  logic [OP_W-1:0]  s1_a, s1_b;
  mac_mode_e        s1_mode;
  logic             s1_sub, s1_load;
  logic [ACC_W-1:0] s1_addend;
  logic [ACC_W-1:0] prod_ext;

  mac18_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) i_stage (
    .clk(clk), .rst_n(rst_n),
    .valid_d(in_valid), .a_d(a_in), .b_d(b_in), .mode_d(mode_in),
    .sub_d(sub_in), .load_d(load_in), .addend_d(addend_in),
    .valid_q(s1_valid), .a_q(s1_a), .b_q(s1_b), .mode_q(s1_mode),
    .sub_q(s1_sub), .load_q(s1_load), .addend_q(s1_addend)
  );

  mac18_product #(.OP_W(OP_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) i_product (
    .a(s1_a), .b(s1_b), .mode(s1_mode), .prod_ext(prod_ext)
  );

  mac18_accum #(.ACC_W(ACC_W)) i_accum (
    .clk(clk), .rst_n(rst_n),
    .upd(s1_valid), .load(s1_load), .sub(s1_sub),
    .addend(s1_addend), .prod(prod_ext),
    .acc(result), .upd_q(out_valid)
  );

endmodule

// File: rtl/mac18_checker.sv
module mac18_checker
  import mac18_pkg::*;
#(
  parameter int unsigned OP_W   = MAC_OP_W,
  parameter int unsigned HALF_W = MAC_HALF_W,
  parameter int unsigned ACC_W  = MAC_ACC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ACC_W-1:0] result,
  input logic             s1_valid,
  input logic             s1_load,
  input mac_mode_e        s1_mode,
  input logic [ACC_W-1:0] s1_addend,
  input logic [ACC_W-1:0] prod_ext
);

  localparam int unsigned U_W = OP_W - 1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));

  a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_U17) |-> (prod_ext[ACC_W-1:2*U_W] == '0));

  a_r4_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_DOT) |-> (prod_ext[HALF_W-1:0] == '0));

  a_r7_load_base: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_load && prod_ext == '0) |=> (result == $past(s1_addend)));

  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_load && prod_ext == '0) |=> $stable(result));

endmodule

bind dsp_mac18 mac18_checker #(.OP_W(OP_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) i_mac18_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .s1_valid(s1_valid), .s1_load(s1_load), .s1_mode(s1_mode),
  .s1_addend(s1_addend), .prod_ext(prod_ext)
);

// File: tb/test_dsp_mac18.sv
`timescale 1ns/1ps
module test_dsp_mac18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [17:0] a_in = '0, b_in = '0;
  logic [1:0]  mode_in = '0;
  logic        sub_in = 1'b0, load_in = 1'b0;
  logic [43:0] addend_in = '0;
  logic        out_valid;
  logic [43:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  // reference pipeline: stage (input beat just driven) and output view
  longint ref_acc = 0;
  bit     m_v1 = 0, m_v2 = 0;
  logic [43:0] m_r1 = '0, m_r2 = '0;
  string  m_t1 = "R9", m_t2 = "R1";

  localparam longint MASK44 = (longint'(1) <<< 44) - 1;

  always #2.5 clk = ~clk;

  dsp_mac18 i_dsp_mac18 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .mode_in(mode_in), .sub_in(sub_in), .load_in(load_in), .addend_in(addend_in),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint s_val(input longint v, input int bits);
    longint half = longint'(1) <<< (bits - 1);
    return (v >= half) ? v - (half * 2) : v;
  endfunction

  function automatic longint ref_prod(input logic [17:0] a, input logic [17:0] b, input logic [1:0] m);
    longint al, ah, bl, bh;
    if (m == 2'd1) return longint'(a & 18'h1FFFF) * longint'(b & 18'h1FFFF);
    if (m == 2'd2) begin
      al = s_val(longint'(a[8:0]), 9);  ah = s_val(longint'(a[17:9]), 9);
      bl = s_val(longint'(b[8:0]), 9);  bh = s_val(longint'(b[17:9]), 9);
      return (al * bh + ah * bl) * 512;
    end
    return s_val(longint'(a), 18) * s_val(longint'(b), 18);
  endfunction

  function automatic string auto_tag(input bit v, input logic [1:0] m, input bit ld, input bit sb);
    string t;
    if (!v) return "R9";
    case (m)
      2'd1: t = "R3";
      2'd2: t = "R4";
      2'd3: t = "R5";
      default: t = "R2";
    endcase
    t = {t, ld ? " R7" : " R6"};
    if (sb) t = {t, " R8"};
    return t;
  endfunction

  task automatic compare();
    n_cmp++;
    if (out_valid !== m_v2 || result !== m_r2) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b result=%h expected out_valid=%0b result=%h",
               m_t2, out_valid, result, m_v2, m_r2);
    end
  endtask

  task automatic step(input bit v, input logic [17:0] a, input logic [17:0] b,
                      input logic [1:0] m, input bit sb, input bit ld,
                      input logic [43:0] add, input string tag);
    longint base, p;
    @(negedge clk);
    compare();
    m_r2 = m_v1 ? m_r1 : m_r2;
    m_v2 = m_v1;
    m_t2 = m_t1;
    in_valid = v; a_in = a; b_in = b; mode_in = m;
    sub_in = sb; load_in = ld; addend_in = add;
    m_v1 = v;
    m_t1 = (tag == "") ? auto_tag(v, m, ld, sb) : tag;
    if (v) begin
      base = ld ? longint'(add) : ref_acc;
      p = ref_prod(a, b, m);
      ref_acc = (sb ? base - p : base + p) & MASK44;
      m_r1 = 44'(ref_acc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 2'd0, 0, 0, '0, "");
  endtask

  initial begin
    #(200_000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R1: out_valid=%0b result=%h expected out_valid=0 result=0", out_valid, result);
    end
    rst_n = 1'b1;
    step(0, '0, '0, 2'd0, 0, 0, '0, "R1");
    idle(2);

    // R2: signed extremes, start with a load from zero
    step(1, 18'h20000, 18'h20000, 2'd0, 0, 1, '0, "");
    step(1, 18'h1FFFF, 18'h20000, 2'd0, 0, 0, '0, "");
    step(1, 18'h3FFFF, 18'h00005, 2'd0, 0, 0, '0, "");
    // R3: bit 17 ignored, zero extension
    step(1, 18'h3FFFF, 18'h3FFFF, 2'd1, 0, 1, '0, "");
    step(1, 18'h20003, 18'h00007, 2'd1, 0, 0, '0, "");
    // R4: dot product extremes and mixed signs
    step(1, {9'h100, 9'h100}, {9'h100, 9'h100}, 2'd2, 0, 1, '0, "");
    step(1, {9'h0FF, 9'h100}, {9'h003, 9'h1FF}, 2'd2, 0, 0, '0, "");
    step(1, {9'h001, 9'h002}, {9'h003, 9'h004}, 2'd2, 1, 0, '0, "");
    // R5: reserved mode behaves as signed
    step(1, 18'h2ABCD, 18'h01234, 2'd3, 0, 1, 44'h123, "");
    // R7/R8 back to back: load with subtract right after accumulating beats
    step(1, 18'h00010, 18'h00010, 2'd0, 0, 0, '0, "");
    step(1, 18'h00003, 18'h00004, 2'd0, 1, 1, 44'h0000_0001_0000, "");
    step(1, 18'h00002, 18'h00002, 2'd0, 1, 0, '0, "");
    idle(1);
    // R10: wrap upward and downward
    step(1, 18'h00001, 18'h00001, 2'd0, 0, 1, 44'hFFF_FFFF_FFFF, "R10 R7");
    step(1, 18'h00001, 18'h00001, 2'd0, 1, 0, '0, "R10 R8");
    step(1, 18'h00001, 18'h00001, 2'd0, 1, 1, '0, "R10 R8");
    idle(3);

    // random mix of all modes, loads, subtractions and gaps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 18'($urandom), 18'($urandom), 2'($urandom),
           1'($urandom), ($urandom % 5) == 0, {12'($urandom), 32'($urandom)}, "");
    end
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule